// File: doc/BRIEF.md
# Wide Pseudo-Random Beat Generator and Read Checker

This block feeds a memory traffic tester with pseudo-random data. A 128-bit linear feedback shift register builds a 256-bit data beat for every accepted write. A second register, loaded with the same seed, rebuilds the same beat sequence so that data returning on the read channel can be compared beat by beat. The two registers are independent. Reads may therefore run ahead of, behind or interleaved with writes, as long as the read beats come back in the same order in which they were written.

The test controller supplies the seed. A seed is taken in while reset is held, and again on any restart pulse. The handshake logic around the block reports each completed beat with a one-cycle fire strobe on each channel. The block owns no bus handshake and no address generation.

A small state machine follows the checking. After reset or restart it sits in ARMED. A matching read beat takes it from ARMED to TRACK. A mismatching read beat in ARMED or TRACK takes it to FAULT. A restart takes TRACK back to ARMED. FAULT holds until reset. The error output is high exactly while the machine is in FAULT.

Top module: `lfsr_beat_engine`

## Requirements
- R1: While `rst_n` is low, each clock loads both generators from `seed_i`. After release, `wr_data_o` equals {S, step(S)} with S the loaded state, and `err_o` is 0.
- R2: When `wr_fire_i` and `restart_i` are both low at a clock edge, `wr_data_o` keeps its value across that edge.
- R3: step(s) is a Galois left shift: (s<<1), XORed with a mask when s[127] was 1. The mask has bits 126, 101, 99 and 0 set. Each write fire moves the write state two steps, so the next beat from state S is {step²(S), step³(S)}.
- R4: The first read beat after reset is checked against the first write beat of the seed, whether or not any write has happened.
- R5: A read fire whose data differs from the expected beat in any single one of the 256 bit positions sets `err_o` one clock later.
- R6: Once set, `err_o` stays 1 through restarts, idle cycles and later matching reads. Only reset clears it.
- R7: Data on `rd_data_i` while `rd_fire_i` is low is not compared and never sets `err_o`.
- R8: A `restart_i` pulse reloads both generators from `seed_i`. If `wr_fire_i` is high in the same cycle, the restart wins.
- R9: An all-zero seed is replaced by the fallback state 128'h1 wherever a seed is loaded.
- R10: The read generator moves two steps only on a read fire, so matching reads that are separated by idle cycles raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seed |
| seed_i | input | 128 | Seed from the test controller |
| restart_i | input | 1 | Reloads both generators from the seed |
| wr_fire_i | input | 1 | A write beat was accepted this cycle |
| wr_data_o | output | 256 | Current write beat |
| rd_fire_i | input | 1 | A read beat is presented this cycle |
| rd_data_i | input | 256 | Read beat to be checked |
| err_o | output | 1 | Sticky mismatch flag |

## Verification
The assertions assume that the fire strobes are single-cycle reports of completed beats. They also assume that `seed_i` is stable in any cycle in which restart is pulsed, because the restart check compares the reloaded beat against the seed value sampled in that cycle. The bench changes the seed only while reset is held, and it keeps every fire and restart pulse one clock long. Read data is either the exact expected beat or that beat with exactly one flipped bit. Deliberate garbage is placed on the read bus only while the read fire strobe is low.

// File: rtl/lfsr_beat_pkg.sv
package lfsr_beat_pkg;

    localparam int STATE_W = 128;
    localparam int BEAT_W  = 2 * STATE_W;

    // feedback mask for x^128 + x^126 + x^101 + x^99 + 1
    localparam logic [STATE_W-1:0] TAP_MASK =
        (STATE_W'(1) << 126) | (STATE_W'(1) << 101) |
        (STATE_W'(1) << 99)  | STATE_W'(1);

    localparam logic [STATE_W-1:0] SEED_FALLBACK = STATE_W'(1);

    typedef enum logic [1:0] {
        CHK_ARMED = 2'd0,
        CHK_TRACK = 2'd1,
        CHK_FAULT = 2'd2
    } chk_state_e;

    function automatic logic [STATE_W-1:0] lfsr_step(input logic [STATE_W-1:0] s);
        return {s[STATE_W-2:0], 1'b0} ^ (s[STATE_W-1] ? TAP_MASK : '0);
    endfunction

    function automatic logic [BEAT_W-1:0] beat_of(input logic [STATE_W-1:0] s);
        return {s, lfsr_step(s)};
    endfunction

    function automatic logic [STATE_W-1:0] seed_fix(input logic [STATE_W-1:0] s);
        return (s == '0) ? SEED_FALLBACK : s;
    endfunction

endpackage

// File: rtl/lfsr_beat_gen.sv
module lfsr_beat_gen
    import lfsr_beat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] seed_i,
    input  logic               load_i,
    input  logic               adv_i,
    output logic [BEAT_W-1:0]  beat_o
);

    logic [STATE_W-1:0] state_q;

    // reload has priority over advance
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            state_q <= seed_fix(seed_i);
        end else if (adv_i) begin
            state_q <= lfsr_step(lfsr_step(state_q));
        end
    end

    assign beat_o = beat_of(state_q);

endmodule

// File: rtl/beat_compare.sv
module beat_compare #(
    parameter int DATA_W = 256,
    parameter int LANE_W = 32
) (
    input  logic              valid_i,
    input  logic [DATA_W-1:0] actual_i,
    input  logic [DATA_W-1:0] expect_i,
    output logic              miss_o
);

    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_diff;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_diff[g] = |(actual_i[g*LANE_W +: LANE_W] ^ expect_i[g*LANE_W +: LANE_W]);
    end

    assign miss_o = valid_i && (|lane_diff);

endmodule

// File: rtl/lfsr_beat_engine.sv
module lfsr_beat_engine
    import lfsr_beat_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] seed_i,
    input  logic               restart_i,
    input  logic               wr_fire_i,
    output logic [BEAT_W-1:0]  wr_data_o,
    input  logic               rd_fire_i,
    input  logic [BEAT_W-1:0]  rd_data_i,
    output logic               err_o
);

    logic [BEAT_W-1:0] rd_expect;
    logic              mismatch;
    chk_state_e        state_q;
    chk_state_e        state_d;

    lfsr_beat_gen i_wr_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (seed_i),
        .load_i (restart_i),
        .adv_i  (wr_fire_i),
        .beat_o (wr_data_o)
    );

    lfsr_beat_gen i_rd_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (seed_i),
        .load_i (restart_i),
        .adv_i  (rd_fire_i),
        .beat_o (rd_expect)
    );

    beat_compare #(
        .DATA_W (BEAT_W),
        .LANE_W (LANE_W)
    ) i_cmp (
        .valid_i  (rd_fire_i),
        .actual_i (rd_data_i),
        .expect_i (rd_expect),
        .miss_o   (mismatch)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CHK_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CHK_ARMED: begin
                if (mismatch)       state_d = CHK_FAULT;
                else if (rd_fire_i) state_d = CHK_TRACK;
            end
            CHK_TRACK: begin
                if (mismatch)       state_d = CHK_FAULT;
                else if (restart_i) state_d = CHK_ARMED;
            end
            CHK_FAULT: state_d = CHK_FAULT;
            default:   state_d = CHK_FAULT;
        endcase
    end

    always_comb begin
        err_o = (state_q == CHK_FAULT);
    end

endmodule

// File: rtl/lfsr_beat_engine_chk.sv
module lfsr_beat_engine_chk
    import lfsr_beat_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [STATE_W-1:0] seed_i,
    input logic               restart_i,
    input logic               wr_fire_i,
    input logic [BEAT_W-1:0]  wr_data_o,
    input logic               rd_fire_i,
    input logic               err_o
);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R6

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_fire_i && !restart_i) |=> $stable(wr_data_o)); // R2

    AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire_i && !restart_i) |=> (wr_data_o != $past(wr_data_o))); // R3

    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_fire_i && !err_o) |=> !err_o); // R7

    AST_RESTART_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (wr_data_o == beat_of(seed_fix($past(seed_i))))); // R8

endmodule

bind lfsr_beat_engine lfsr_beat_engine_chk i_chk (.*);

// File: tb/test_lfsr_beat_engine.sv
module test_lfsr_beat_engine;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [127:0] seed_i;
    logic         restart_i;
    logic         wr_fire_i;
    logic [255:0] wr_data_o;
    logic         rd_fire_i;
    logic [255:0] rd_data_i;
    logic         err_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [127:0] wexp;
    logic [127:0] rexp;

    always #10 clk = ~clk;

    lfsr_beat_engine i_lfsr_beat_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_i    (seed_i),
        .restart_i (restart_i),
        .wr_fire_i (wr_fire_i),
        .wr_data_o (wr_data_o),
        .rd_fire_i (rd_fire_i),
        .rd_data_i (rd_data_i),
        .err_o     (err_o)
    );

    function automatic logic [127:0] nxt(input logic [127:0] s);
        logic [127:0] m;
        m = '0;
        m[126] = 1'b1;
        m[101] = 1'b1;
        m[99]  = 1'b1;
        m[0]   = 1'b1;
        return s[127] ? ((s << 1) ^ m) : (s << 1);
    endfunction

    function automatic logic [255:0] bt(input logic [127:0] s);
        return {s, nxt(s)};
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic wf, input logic rf, input logic rs, input logic [255:0] rd);
        wr_fire_i = wf;
        rd_fire_i = rf;
        restart_i = rs;
        rd_data_i = rd;
        @(negedge clk);
        wr_fire_i = 1'b0;
        rd_fire_i = 1'b0;
        restart_i = 1'b0;
    endtask

    task automatic do_reset(input logic [127:0] s);
        rst_n = 1'b0;
        seed_i = s;
        tick(1'b0, 1'b0, 1'b0, '0);
        tick(1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        wexp = (s == '0) ? 128'h1 : s;
        rexp = wexp;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [127:0] seeds [4];
        seeds[0] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        seeds[1] = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
        seeds[2] = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
        seeds[3] = 128'h0000_0000_0000_0001_8000_0000_0000_0000;
        rst_n = 1'b0;
        seed_i = '0;
        restart_i = 1'b0;
        wr_fire_i = 1'b0;
        rd_fire_i = 1'b0;
        rd_data_i = '0;
        @(negedge clk);

        for (int k = 0; k < 4; k++) begin
            do_reset(seeds[k]);
            check("R1 reset beat", wr_data_o, bt(wexp));
            check("R1 reset err", {255'b0, err_o}, 256'b0);
            for (int i = 0; i < 18; i++) begin
                logic wf;
                logic rf;
                logic [255:0] rd;
                wf = (i % 3 == 2);
                rf = (i % 2 == 0);
                // R7: garbage on the bus while the read strobe is low
                rd = rf ? bt(rexp) : ~bt(rexp);
                tick(wf, rf, 1'b0, rd);
                if (wf) wexp = nxt(nxt(wexp));
                if (rf) rexp = nxt(nxt(rexp));
                check(wf ? "R3 write advance" : "R2 write hold", wr_data_o, bt(wexp));
                check(rf ? ((i == 0) ? "R4 first read" : "R10 read match") : "R7 idle read ignored",
                      {255'b0, err_o}, 256'b0);
            end
            // R8: restart wins over a write fire in the same cycle
            tick(1'b1, 1'b0, 1'b1, '0);
            wexp = (seeds[k] == '0) ? 128'h1 : seeds[k];
            rexp = wexp;
            check("R8 restart beat", wr_data_o, bt(wexp));
            tick(1'b0, 1'b1, 1'b0, bt(rexp));
            rexp = nxt(nxt(rexp));
            check("R8 read after restart", {255'b0, err_o}, 256'b0);
        end

        // R9: zero seed falls back to 128'h1
        do_reset('0);
        check("R9 zero seed", wr_data_o, bt(128'h1));
        tick(1'b0, 1'b1, 1'b0, bt(128'h1));
        check("R9 zero seed read", {255'b0, err_o}, 256'b0);

        // R5: every single-bit flip in the first read beat is caught
        for (int b = 0; b < 256; b++) begin
            logic [255:0] flip;
            flip = '0;
            flip[b] = 1'b1;
            do_reset(seeds[0]);
            tick(1'b0, 1'b1, 1'b0, bt(rexp) ^ flip);
            rexp = nxt(nxt(rexp));
            check("R5 bit flip", {255'b0, err_o}, {255'b0, 1'b1});
        end

        // R6: sticky through matching read, restart and idle
        tick(1'b0, 1'b1, 1'b0, bt(rexp));
        check("R6 sticky after good read", {255'b0, err_o}, {255'b0, 1'b1});
        tick(1'b0, 1'b0, 1'b1, '0);
        tick(1'b0, 1'b0, 1'b0, '0);
        tick(1'b0, 1'b0, 1'b0, '0);
        check("R6 sticky after restart", {255'b0, err_o}, {255'b0, 1'b1});
        do_reset(seeds[1]);
        check("R6 cleared by reset", {255'b0, err_o}, 256'b0);

        finish_run();
    end

endmodule